// File: doc/BRIEF.md
# Serial GPIO pin-pair controller

This block keeps the software-visible state of a bank of serial GPIO pin pairs. Each pair has one input pin and one output pin, and owns a 32-bit control word. The control word holds the output level, the sampled input level, an interrupt enable and a trigger type. A bank of read-only status words holds one pending bit per pair. A simple word-addressed 32-bit bus reads and writes these registers. An external pin-update port moves individual pin levels through the same update path that bus writes use. The serial shift logic that moves levels on and off the chip sits outside this block.

Each accepted change to a control word is handled in one step. A set clear bit drops the pair's pending flag. A flip of the output bit raises a one-cycle strobe for that pair. A flip of the input bit is passed to a per-pair trigger evaluator, which may set the pending flag. A single interrupt line reports whether any flag is pending. A write that would leave a control word unchanged does nothing at all.

Top module: `sgpio_pair_ctrl`

## Requirements
- R1: After reset every control word and every status bit reads 0, `irq` is low and no strobe is raised.
- R2: The word index is the byte offset shifted right by 2, and the two low address bits are ignored. Status words sit at word indices 0..7. The pending bit of pair p is bit p%32 of status word p/32. The control word of pair p sits at word index 8+p and reads back what was stored.
- R3: Bus writes to status words 0..7 leave every pending bit unchanged.
- R4: A control index at or beyond NUM_PAIRS, or any word index at or above 8+256, reads as 0. A write to such an index changes no state.
- R5: A control write, or a pin update, whose value equals the stored word causes no strobe and no change to any pending bit.
- R6: In a write that changes a word, bit 6 (clear) drops the pair's pending bit even when the bit was not pending. Bit 6 is never stored and always reads 0. All other bits are stored as written.
- R7: An accepted update that flips bit 0 (output level) raises `out_chg_strobe[p]` for exactly the cycle after the write.
- R8: An accepted update that flips bit 1 (input level) is checked against the new word's bit 2 (enable) and bits 5:3 (type). The types are 000 falling, 001 rising, 010 level low (new level 0), 011 level high (new level 1) and 1xx either edge. A match sets the pending bit, which is visible the cycle after the write. No match, or a disabled pair, leaves the bit alone.
- R9: `irq` is high exactly when at least one pending bit is set.
- R10: Pin update index 2p sets bit 1 of pair p, and index 2p+1 sets bit 0. The update then follows the same path as a bus write, with the same strobe and trigger behaviour. A pin index at or beyond 2*NUM_PAIRS is ignored.
- R11: When a bus write and a pin update hit the same pair in the same cycle, the bus write is applied and the pin update is dropped. When they hit different pairs, both are applied.
- R12: When one write both clears a pair and makes an input change that matches its trigger, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| pin_upd_valid | input | 1 | Pin level update valid |
| pin_upd_idx | input | PIN_W | Pin number (even = input, odd = output) |
| pin_upd_level | input | 1 | New pin level |
| out_chg_strobe | output | NUM_PAIRS | One-cycle pulse per pair on an output-level change |
| irq | output | 1 | Combined pending interrupt |

## Verification
A wrong control word shows up on the next read of that pair, and also in a later trigger decision, because enable, type and previous input level all come from the stored word. A wrong pending bit shows on `irq` in the cycle after the faulty update, and on the matching status-word read. A lost or spurious output-bit change shows on `out_chg_strobe` in the very next cycle. The bench therefore checks the strobe vector and `irq` after every cycle and compares every read against its model. Most faults are caught within one cycle of the update that causes them.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;
   localparam int F_OUT    = 0;
   localparam int F_IN     = 1;
   localparam int F_EN     = 2;
   localparam int F_TYP_LO = 3;
   localparam int F_CLR    = 6;
   localparam int STAT_WORDS = 8;
   localparam int CTRL_BASE  = 8;
   localparam int MAX_PAIRS  = 256;

   typedef enum logic [2:0] {
      TRG_FALL = 3'd0,
      TRG_RISE = 3'd1,
      TRG_LOW  = 3'd2,
      TRG_HIGH = 3'd3,
      TRG_BOTH = 3'd4
   } trig_e;
endpackage

// File: rtl/sgpio_trigger.sv
module sgpio_trigger
   import sgpio_pkg::*;
(
   input  logic       en,
   input  logic [2:0] typ,
   input  logic       prev_lvl,
   input  logic       curr_lvl,
   input  logic       chg,
   output logic       hit
);
   logic rise, fall;
   assign rise = chg & curr_lvl & ~prev_lvl;
   assign fall = chg & ~curr_lvl & prev_lvl;

   always_comb begin
      hit = 1'b0;
      if (en && chg) begin
         if (typ[2]) hit = rise | fall;
         else begin
            unique case (trig_e'(typ))
               TRG_FALL: hit = fall;
               TRG_RISE: hit = rise;
               TRG_LOW:  hit = ~curr_lvl;
               TRG_HIGH: hit = curr_lvl;
               default:  hit = 1'b0;
            endcase
         end
      end
   end
endmodule

// File: rtl/sgpio_pair.sv
module sgpio_pair
   import sgpio_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_valid,
   input  logic [DATA_W-1:0] upd_value,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              stat_q,
   output logic              strobe_q
);
   logic [DATA_W-1:0] diff;
   logic              act, hit;

   assign diff = ctrl_q ^ upd_value;
   assign act  = upd_valid && (diff != '0);

   sgpio_trigger u_trg (
      .en       (upd_value[F_EN]),
      .typ      (upd_value[F_TYP_LO +: 3]),
      .prev_lvl (ctrl_q[F_IN]),
      .curr_lvl (upd_value[F_IN]),
      .chg      (diff[F_IN]),
      .hit      (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         stat_q   <= 1'b0;
         strobe_q <= 1'b0;
      end else if (act) begin
         ctrl_q          <= upd_value;
         ctrl_q[F_CLR]   <= 1'b0;
         strobe_q        <= diff[F_OUT];
         if (hit)                   stat_q <= 1'b1;
         else if (upd_value[F_CLR]) stat_q <= 1'b0;
      end else begin
         strobe_q <= 1'b0;
      end
   end
endmodule

// File: rtl/sgpio_pair_ctrl.sv
module sgpio_pair_ctrl
   import sgpio_pkg::*;
#(
   parameter int NUM_PAIRS = 40,
   parameter int ADDR_W    = 12,
   parameter int PIN_W     = $clog2(2 * NUM_PAIRS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic                 pin_upd_valid,
   input  logic [PIN_W-1:0]     pin_upd_idx,
   input  logic                 pin_upd_level,
   output logic [NUM_PAIRS-1:0] out_chg_strobe,
   output logic                 irq
);
   localparam int WIDX_W = ADDR_W - 2;

   if (NUM_PAIRS < 2 || NUM_PAIRS > MAX_PAIRS)
      $error("NUM_PAIRS out of supported range");
   if ((CTRL_BASE + MAX_PAIRS) > (1 << WIDX_W))
      $error("ADDR_W too small for the register map");
   if ((1 << PIN_W) < 2 * NUM_PAIRS)
      $error("PIN_W too small for the pin count");

   logic [WIDX_W-1:0]           widx;
   logic [NUM_PAIRS-1:0][31:0]  ctrl_arr;
   logic [NUM_PAIRS-1:0]        stat_vec;

   assign widx = bus_addr[ADDR_W-1:2];

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      logic        bus_hit, pin_hit;
      logic [31:0] pin_val, upd_val;

      assign bus_hit = bus_sel && bus_wr && (widx == WIDX_W'(CTRL_BASE + p));
      assign pin_hit = pin_upd_valid && (pin_upd_idx[PIN_W-1:1] == (PIN_W-1)'(p));

      always_comb begin
         pin_val = ctrl_arr[p];
         if (pin_upd_idx[0]) pin_val[F_OUT] = pin_upd_level;
         else                pin_val[F_IN]  = pin_upd_level;
      end

      assign upd_val = bus_hit ? bus_wdata : pin_val;

      sgpio_pair #(.DATA_W(32)) u_pair (
         .clk       (clk),
         .rst_n     (rst_n),
         .upd_valid (bus_hit | pin_hit),
         .upd_value (upd_val),
         .ctrl_q    (ctrl_arr[p]),
         .stat_q    (stat_vec[p]),
         .strobe_q  (out_chg_strobe[p])
      );
   end

   assign irq = |stat_vec;

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         if (widx < WIDX_W'(STAT_WORDS)) begin
            for (int p = 0; p < NUM_PAIRS; p++)
               if (widx == WIDX_W'(p / 32)) bus_rdata[p % 32] = stat_vec[p];
         end else begin
            for (int p = 0; p < NUM_PAIRS; p++)
               if (widx == WIDX_W'(CTRL_BASE + p)) bus_rdata = ctrl_arr[p];
         end
      end
   end
endmodule

// File: rtl/sgpio_pair_ctrl_chk.sv
module sgpio_pair_ctrl_chk
   import sgpio_pkg::*;
#(
   parameter int NUM_PAIRS = 40,
   parameter int ADDR_W    = 12
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        bus_sel,
   input logic                        bus_wr,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic [31:0]                 bus_wdata,
   input logic [31:0]                 bus_rdata,
   input logic                        pin_upd_valid,
   input logic [NUM_PAIRS-1:0]        out_chg_strobe,
   input logic                        irq,
   input logic [NUM_PAIRS-1:0]        stat_vec,
   input logic [NUM_PAIRS-1:0][31:0]  ctrl_arr
);
   int  widx, cidx;
   logic ctrl_wr;
   assign widx    = int'(bus_addr[ADDR_W-1:2]);
   assign cidx    = widx - CTRL_BASE;
   assign ctrl_wr = bus_sel && bus_wr && widx >= CTRL_BASE && cidx < NUM_PAIRS;

   a_r3_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && widx < STAT_WORDS && !pin_upd_valid) |=> $stable(stat_vec));

   a_r6_clear_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && bus_wdata[F_CLR] && bus_wdata[F_IN] == ctrl_arr[cidx][F_IN])
      |=> !stat_vec[$past(cidx)]);

   a_r7_strobe_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (out_chg_strobe != '0) |-> $past((bus_sel && bus_wr) || pin_upd_valid));

   a_r9_irq_drops_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(bus_sel && bus_wr && bus_wdata[F_CLR]));

   a_r4_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && widx >= CTRL_BASE + NUM_PAIRS) |-> bus_rdata == '0);
endmodule

bind sgpio_pair_ctrl sgpio_pair_ctrl_chk #(.NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_sel        (bus_sel),
   .bus_wr         (bus_wr),
   .bus_addr       (bus_addr),
   .bus_wdata      (bus_wdata),
   .bus_rdata      (bus_rdata),
   .pin_upd_valid  (pin_upd_valid),
   .out_chg_strobe (out_chg_strobe),
   .irq            (irq),
   .stat_vec       (stat_vec),
   .ctrl_arr       (ctrl_arr)
);

// File: tb/tb_sgpio_pair_ctrl.sv
module tb_sgpio_pair_ctrl;
   localparam int NP = 40;
   localparam int AW = 12;
   localparam int PW = $clog2(2 * NP);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          pin_upd_valid = 1'b0;
   logic [PW-1:0] pin_upd_idx = '0;
   logic          pin_upd_level = 1'b0;
   logic [NP-1:0] out_chg_strobe;
   logic          irq;

   int checks = 0, errors = 0;
   logic [31:0] m_ctrl [NP];
   logic        m_stat [NP];

   always #10 clk = ~clk;

   sgpio_pair_ctrl #(.NUM_PAIRS(NP), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_upd_valid(pin_upd_valid), .pin_upd_idx(pin_upd_idx),
      .pin_upd_level(pin_upd_level), .out_chg_strobe(out_chg_strobe), .irq(irq));

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(input int w);
      logic [31:0] r = '0;
      if (w < 8) begin
         for (int p = 0; p < NP; p++) if (p / 32 == w) r[p % 32] = m_stat[p];
      end else if (w - 8 < NP) r = m_ctrl[w - 8];
      return r;
   endfunction

   function automatic bit m_apply(input int p, input logic [31:0] nv);
      logic [31:0] old = m_ctrl[p];
      logic [31:0] d = old ^ nv;
      bit hit = 0;
      if (d == '0) return 0;
      if (nv[2] && d[1]) begin
         if (nv[5]) hit = 1;
         else case (nv[4:3])
            2'd0: hit = !nv[1];
            2'd1: hit = nv[1];
            2'd2: hit = !nv[1];
            default: hit = nv[1];
         endcase
      end
      if (nv[6]) m_stat[p] = 0;
      if (hit) m_stat[p] = 1;
      m_ctrl[p] = nv & ~32'h40;
      return d[0];
   endfunction

   function automatic logic m_irq();
      logic r = 0;
      for (int p = 0; p < NP; p++) r |= m_stat[p];
      return r;
   endfunction

   // Called at a negedge; drives one cycle, checks read data before the edge,
   // strobe and irq at the following negedge.
   task automatic cyc(input bit bv, input bit bw, input int w, input logic [31:0] d,
                      input bit pv, input int pin, input bit lv, input string req);
      logic [NP-1:0] es = '0;
      int bp = -1;
      bus_sel = bv; bus_wr = bw; bus_addr = AW'(w * 4 + 0); bus_wdata = d;
      pin_upd_valid = pv; pin_upd_idx = PW'(pin); pin_upd_level = lv;
      #2;
      if (bv && !bw) chk(bus_rdata == m_read(w), {req, " read"}, 64'(bus_rdata), 64'(m_read(w)));
      if (bv && bw && w >= 8 && w - 8 < NP) bp = w - 8;
      if (pv && pin < 2 * NP && pin / 2 != bp) begin
         logic [31:0] nv = m_ctrl[pin / 2];
         if (pin % 2) nv[0] = lv; else nv[1] = lv;
         es[pin / 2] = m_apply(pin / 2, nv);
      end
      if (bp >= 0) es[bp] = m_apply(bp, d);
      @(negedge clk);
      chk(out_chg_strobe == es, {req, " strobe"}, 64'(out_chg_strobe), 64'(es));
      chk(irq == m_irq(), {req, " irq"}, 64'(irq), 64'(m_irq()));
      bus_sel = 0; bus_wr = 0; pin_upd_valid = 0;
   endtask

   task automatic wr(input int w, input logic [31:0] d, input string req);
      cyc(1, 1, w, d, 0, 0, 0, req);
   endtask
   task automatic rd(input int w, input string req);
      cyc(1, 0, w, 0, 0, 0, 0, req);
   endtask
   task automatic pin(input int n, input bit lv, input string req);
      cyc(0, 0, 0, 0, 1, n, lv, req);
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int p = 0; p < NP; p++) begin m_ctrl[p] = '0; m_stat[p] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(0, "R1"); rd(1, "R1"); rd(8, "R1"); rd(8 + NP - 1, "R1");
      // R7 output change strobe, R2 readback
      wr(8 + 3, 32'h1, "R7"); rd(8 + 3, "R2");
      // R5 identical value is quiet
      wr(8 + 3, 32'h1, "R5");
      // R8 rising trigger via R10 input pin, status bit position R2
      wr(8 + 5, 32'h0C, "R8"); pin(10, 1, "R10"); rd(0, "R2");
      // R3 status words ignore writes
      wr(0, 32'hFFFF_FFFF, "R3"); rd(0, "R3"); wr(1, 32'h0, "R3"); rd(1, "R3");
      // R6 clear while input unchanged; bit 6 not stored
      wr(8 + 5, 32'h4E, "R6"); rd(8 + 5, "R6"); rd(0, "R6");
      wr(8 + 7, 32'h40, "R6"); rd(8 + 7, "R6");
      // R8 level high on pair 35, word 1
      wr(8 + 35, 32'h1C, "R8"); pin(70, 1, "R8"); rd(1, "R2");
      // R8 disabled pair does nothing
      wr(8 + 12, 32'h08, "R8"); pin(24, 1, "R8"); rd(0, "R8");
      // R8 level low, falling, dual edge
      wr(8 + 13, 32'h16, "R8"); pin(26, 0, "R8");
      wr(8 + 14, 32'h24, "R8"); pin(28, 1, "R8"); wr(8 + 14, 32'h64, "R8"); pin(28, 0, "R8");
      // R10 odd pin drives output, out-of-range pin ignored
      pin(9, 1, "R10"); rd(8 + 4, "R10"); pin(2 * NP + 5, 1, "R10");
      // R4 out-of-range control and unmapped offsets
      wr(8 + NP + 2, 32'hABCD, "R4"); rd(8 + NP + 2, "R4"); rd(300, "R4"); rd(5, "R4");
      // R11 bus beats pin on same pair; different pairs both apply
      cyc(1, 1, 8 + 6, 32'h3, 1, 12, 0, "R11"); rd(8 + 6, "R11");
      cyc(1, 1, 8 + 8, 32'h1, 1, 19, 1, "R11"); rd(8 + 9, "R11");
      // R12 clear and new falling match in one write
      wr(8 + 20, 32'h04, "R12"); pin(40, 1, "R12"); pin(40, 0, "R12");
      wr(8 + 20, 32'h46, "R12"); wr(8 + 20, 32'h44, "R12"); rd(0, "R12");
      // R9 irq tracks pending set
      for (int p = 0; p < NP; p++) if (m_stat[p]) wr(8 + p, m_ctrl[p] | 32'h40, "R9");
      rd(0, "R9"); rd(1, "R9");
      // Random mix
      for (int i = 0; i < 2000; i++) begin
         int op = $urandom_range(0, 9);
         int p = $urandom_range(0, NP + 3);
         logic [31:0] d = {$urandom_range(0, 3) == 0 ? 25'($urandom) : 25'd0, 7'($urandom)};
         if (p < NP && $urandom_range(0, 4) == 0) d = m_ctrl[p] | ($urandom_range(0, 1) ? 32'h40 : 32'h0);
         if (op < 4) wr(8 + p, d, "R8");
         else if (op < 7) pin($urandom_range(0, 2 * NP + 2), 1'($urandom), "R10");
         else if (op < 8) cyc(1, 1, 8 + p, d, 1, $urandom_range(0, 2 * NP - 1), 1'($urandom), "R11");
         else if (op < 9) rd($urandom_range(0, 8 + NP + 2), "R2");
         else wr($urandom_range(0, 7), $urandom, "R3");
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule